// File: doc/BRIEF.md
# DMA Channel Programming Port

This block is the host-facing register file of a four-channel DMA controller in the classic PC layout. A host reaches it over a 4-bit I/O offset bus with 8-bit data. Each channel keeps a 16-bit base and current address and a 16-bit base and current count. All of these values pass through single byte-wide offsets. One shared byte-pointer flip-flop decides whether an access goes to the low or the high half.

The block also decodes the control writes: command, software request, single-channel mask, clear-all-masks, write-all-masks, mode, pointer clear and master clear. It also returns a status byte. Toward the transfer engine it presents the masks, the per-channel mode fields and the loaded and current values. It accepts a per-channel step pulse, which advances a channel's current address and count and raises its terminal-count flag. Bus arbitration and the memory data path are not part of this block.

Top module: `dmac_regport`

## Requirements
- R1: After reset every channel mask bit is 1, the pointer flip-flop selects the low byte, the status byte reads 0x00, and all address, count, mode and command values are 0.
- R2: A write to offset 2n loads channel n's address and a write to offset 2n+1 loads its count (n = 0..3). The low byte goes first and the high byte second. Each byte is loaded into both the base and the current copy.
- R3: A read of offset 2n or 2n+1 returns channel n's current address or current count, one byte per read: low byte first, then high byte. io_rdata is valid one cycle after io_rd.
- R4: A write of any data to offset 12 makes the next address or count access use the low byte. Every address or count read or write toggles the pointer.
- R5: A write to offset 10 uses data bits 1:0 as the channel. Bit 2 = 1 masks that channel and bit 2 = 0 unmasks it. Other channels keep their masks.
- R6: A write to offset 14 clears all four masks. A write to offset 15 loads the masks from data bits 3:0 (bit n is channel n).
- R7: A write to offset 11 stores data bits 7:2 as channel (data bits 1:0)'s 6-bit mode field. In that field, bit 2 (data bit 4) is auto-initialise and bit 3 (data bit 5) selects address decrement.
- R8: A write to offset 8 stores the command byte. A write to offset 9 sets (data bit 2 = 1) or clears (data bit 2 = 0) the software request of the channel in data bits 1:0.
- R9: A read of offset 8 returns terminal-count flags in bits 3:0 and, in bits 7:4, software request OR eng_dreq. The read clears the terminal-count flags it returned. A flag that is raised in the same cycle as the read survives.
- R10: A step on channel n decrements the current count and adds +1 to the current address, or -1 when decrement mode is set. A step at current count 0 sets the channel's terminal-count flag. With auto-initialise set, that step reloads both current values from base. Without it, the count wraps to 0xFFFF.
- R11: A write to offset 13 clears the pointer, sets all masks, and clears the command, requests, modes and terminal-count flags. Addresses and counts are kept.
- R12: A step on a channel in the same cycle as a host write to that channel's address or count offset is dropped. The write takes effect alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Register offset |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered read data |
| eng_step | input | NCH | One transfer done per channel |
| eng_dreq | input | NCH | Device request lines shown in status |
| ch_mask | output | NCH | Channel mask bits, 1 = disabled |
| ch_mode | output | NCH*6 | Mode field per channel |
| cmd_out | output | 8 | Command byte |
| base_addr_o | output | NCH*AW | Base addresses |
| base_cnt_o | output | NCH*AW | Base counts |
| cur_addr_o | output | NCH*AW | Current addresses |
| cur_cnt_o | output | NCH*AW | Current counts |

## Verification
Two pairs of actions can land in the same cycle: a status read together with a terminal-count step, and a host count write together with a step on that channel. The bench drives each pair on the same clock edge. For the first pair, it expects the read to return the flag's old value and a second status read to show the flag set. For the second pair, it expects the written byte to appear with no decrement of the count and no change in the current address.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int DW = 8;
  localparam int MW = 6;
  localparam logic [3:0] OFS_CMD     = 4'd8;
  localparam logic [3:0] OFS_REQ     = 4'd9;
  localparam logic [3:0] OFS_SMASK   = 4'd10;
  localparam logic [3:0] OFS_MODE    = 4'd11;
  localparam logic [3:0] OFS_CLRFF   = 4'd12;
  localparam logic [3:0] OFS_MCLR    = 4'd13;
  localparam logic [3:0] OFS_CLRMASK = 4'd14;
  localparam logic [3:0] OFS_WMASK   = 4'd15;
  localparam int MODE_AUTO = 2;
  localparam int MODE_DEC  = 3;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          hi_sel,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  input  logic          dec,
  input  logic          autoinit,
  output logic [AW-1:0] base_addr,
  output logic [AW-1:0] base_cnt,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_cnt,
  output logic          tc_pulse
);
  assign tc_pulse = step && (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else if (wr_addr || wr_cnt) begin
      if (wr_addr) begin
        if (hi_sel) begin
          base_addr[AW-1:DW] <= wdata;
          cur_addr[AW-1:DW]  <= wdata;
        end else begin
          base_addr[DW-1:0] <= wdata;
          cur_addr[DW-1:0]  <= wdata;
        end
      end
      if (wr_cnt) begin
        if (hi_sel) begin
          base_cnt[AW-1:DW] <= wdata;
          cur_cnt[AW-1:DW]  <= wdata;
        end else begin
          base_cnt[DW-1:0] <= wdata;
          cur_cnt[DW-1:0]  <= wdata;
        end
      end
    end else if (step) begin
      if (tc_pulse && autoinit) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_cnt  <= cur_cnt - 1'b1;
        cur_addr <= dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] dreq,
  output logic          ff_hi,
  output logic [NCH-1:0] mask,
  output logic [NCH*MW-1:0] mode_flat,
  output logic [DW-1:0] cmd,
  output logic [NCH-1:0] tc_flags,
  output logic [DW-1:0] status
);
  logic [MW-1:0]  mode_q [NCH];
  logic [NCH-1:0] req_q;
  logic           w_mclr, w_ch, rd_stat;
  logic [CW-1:0]  sel;

  assign w_mclr  = io_wr && (io_addr == OFS_MCLR);
  assign w_ch    = (io_wr || io_rd) && !io_addr[3];
  assign rd_stat = io_rd && (io_addr == OFS_CMD);
  assign sel     = io_wdata[CW-1:0];
  assign status  = {req_q | dreq, tc_flags};

  always_ff @(posedge clk) begin
    if (rst || w_mclr) begin
      ff_hi    <= 1'b0;
      mask     <= '1;
      cmd      <= '0;
      req_q    <= '0;
      tc_flags <= '0;
    end else begin
      if (io_wr && io_addr == OFS_CLRFF) ff_hi <= 1'b0;
      else if (w_ch)                     ff_hi <= !ff_hi;
      if (io_wr) begin
        case (io_addr)
          OFS_CMD:     cmd        <= io_wdata;
          OFS_REQ:     req_q[sel] <= io_wdata[2];
          OFS_SMASK:   mask[sel]  <= io_wdata[2];
          OFS_CLRMASK: mask       <= '0;
          OFS_WMASK:   mask       <= io_wdata[NCH-1:0];
          default: ;
        endcase
      end
      tc_flags <= (rd_stat ? '0 : tc_flags) | tc_set;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst || w_mclr)
        mode_q[n] <= '0;
      else if (io_wr && io_addr == OFS_MODE && sel == CW'(n))
        mode_q[n] <= io_wdata[DW-1:2];
    end
    assign mode_flat[n*MW +: MW] = mode_q[n];
  end
endmodule

// File: rtl/dmac_regport.sv
module dmac_regport
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [NCH-1:0]    eng_step,
  input  logic [NCH-1:0]    eng_dreq,
  output logic [NCH-1:0]    ch_mask,
  output logic [NCH*6-1:0]  ch_mode,
  output logic [7:0]        cmd_out,
  output logic [NCH*AW-1:0] base_addr_o,
  output logic [NCH*AW-1:0] base_cnt_o,
  output logic [NCH*AW-1:0] cur_addr_o,
  output logic [NCH*AW-1:0] cur_cnt_o
);
  localparam int CW = $clog2(NCH);

  logic           ff_hi;
  logic [NCH-1:0] tc_flags, tc_set;
  logic [DW-1:0]  status;
  logic [AW-1:0]  cur_a [NCH];
  logic [AW-1:0]  cur_c [NCH];
  logic [CW-1:0]  ch_sel;

  assign ch_sel = io_addr[CW:1];

  dmac_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .tc_set(tc_set), .dreq(eng_dreq), .ff_hi(ff_hi),
    .mask(ch_mask), .mode_flat(ch_mode), .cmd(cmd_out), .tc_flags(tc_flags),
    .status(status)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit, wa, wc;
    assign hit = io_wr && !io_addr[3] && (ch_sel == CW'(n));
    assign wa  = hit && !io_addr[0];
    assign wc  = hit && io_addr[0];
    dmac_chan #(.AW(AW)) u_chan (
      .clk(clk), .rst(rst), .wr_addr(wa), .wr_cnt(wc), .hi_sel(ff_hi),
      .wdata(io_wdata), .step(eng_step[n] && !hit),
      .dec(ch_mode[n*MW + MODE_DEC]), .autoinit(ch_mode[n*MW + MODE_AUTO]),
      .base_addr(base_addr_o[n*AW +: AW]), .base_cnt(base_cnt_o[n*AW +: AW]),
      .cur_addr(cur_a[n]), .cur_cnt(cur_c[n]), .tc_pulse(tc_set[n])
    );
    assign cur_addr_o[n*AW +: AW] = cur_a[n];
    assign cur_cnt_o[n*AW +: AW]  = cur_c[n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (io_rd) begin
      if (!io_addr[3]) begin
        if (io_addr[0]) io_rdata <= ff_hi ? cur_c[ch_sel][AW-1:DW] : cur_c[ch_sel][DW-1:0];
        else            io_rdata <= ff_hi ? cur_a[ch_sel][AW-1:DW] : cur_a[ch_sel][DW-1:0];
      end else if (io_addr == OFS_CMD) begin
        io_rdata <= status;
      end else begin
        io_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/dmac_regport_chk.sv
module dmac_regport_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [3:0]     io_addr,
  input logic           io_wr,
  input logic           io_rd,
  input logic [NCH-1:0] eng_step,
  input logic [NCH-1:0] ch_mask,
  input logic           ff_hi,
  input logic [NCH-1:0] tc_flags
);
  AST_MCLR_MASKS: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == 4'd13) |=> (ch_mask == '1 && !ff_hi)); // R11
  AST_CLRFF_LOW: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == 4'd12) |=> !ff_hi); // R4
  AST_FF_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    ((io_wr || io_rd) && !io_addr[3]) |=> (ff_hi != $past(ff_hi))); // R4
  AST_CLRMASK_ALL: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == 4'd14) |=> (ch_mask == '0)); // R6
  AST_STAT_CLEARS_TC: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == 4'd8 && eng_step == '0) |=> (tc_flags == '0)); // R9
  AST_TC_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
    (eng_step == '0) |=> ((tc_flags & ~$past(tc_flags)) == '0)); // R10
endmodule

bind dmac_regport dmac_regport_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .eng_step(eng_step), .ch_mask(ch_mask), .ff_hi(ff_hi), .tc_flags(tc_flags)
);

// File: tb/dmac_regport_tb.sv
module dmac_regport_tb;
  localparam int NCH = 4;
  localparam int AW  = 16;

  logic clk = 0, rst = 1;
  logic [3:0] io_addr = '0;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [NCH-1:0] eng_step = '0, eng_dreq = '0, ch_mask;
  logic [NCH*6-1:0] ch_mode;
  logic [7:0] cmd_out;
  logic [NCH*AW-1:0] base_addr_o, base_cnt_o, cur_addr_o, cur_cnt_o;
  int tests = 0, fails = 0;
  logic [7:0] rb;

  always #2.5 clk = ~clk;

  dmac_regport #(.NCH(NCH), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .eng_step(eng_step),
    .eng_dreq(eng_dreq), .ch_mask(ch_mask), .ch_mode(ch_mode),
    .cmd_out(cmd_out), .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o),
    .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    @(negedge clk); io_rd = 0; d = io_rdata;
  endtask

  task automatic step(input int ch);
    @(negedge clk); eng_step = 4'(1 << ch);
    @(negedge clk); eng_step = '0;
  endtask

  task automatic t_reset;
    chk("R1 mask", ch_mask, 4'hF);
    chk("R1 cnt", cur_cnt_o, '0);
    chk("R1 mode", ch_mode, '0);
    rd(4'd8, rb); chk("R1 status", rb, 8'h00);
  endtask

  task automatic t_load_read;
    wr(4'd12, 8'h00);
    wr(4'd4, 8'h34); wr(4'd4, 8'h12);
    wr(4'd5, 8'h03); wr(4'd5, 8'h00);
    chk("R2 base addr", base_addr_o[2*AW +: AW], 16'h1234);
    chk("R2 cur addr", cur_addr_o[2*AW +: AW], 16'h1234);
    chk("R2 base cnt", base_cnt_o[2*AW +: AW], 16'h0003);
    rd(4'd4, rb); chk("R3 lo", rb, 8'h34);
    rd(4'd4, rb); chk("R3 hi", rb, 8'h12);
  endtask

  task automatic t_ptr;
    wr(4'd0, 8'hEE);
    wr(4'd12, 8'h5A);
    wr(4'd0, 8'hAB); wr(4'd0, 8'hCD);
    chk("R4 realign", cur_addr_o[0 +: AW], 16'hCDAB);
  endtask

  task automatic t_masks;
    wr(4'd10, 8'h01); chk("R5 unmask", ch_mask, 4'b1101);
    wr(4'd10, 8'h05); chk("R5 mask", ch_mask, 4'b1111);
    wr(4'd14, 8'h00); chk("R6 clear all", ch_mask, 4'b0000);
    wr(4'd15, 8'h0A); chk("R6 write all", ch_mask, 4'b1010);
  endtask

  task automatic t_mode_cmd;
    wr(4'd11, 8'h47); chk("R7 mode ch3", ch_mode[18 +: 6], 6'h11);
    chk("R7 others", ch_mode[0 +: 18], '0);
    wr(4'd8, 8'h5A); chk("R8 cmd", cmd_out, 8'h5A);
    wr(4'd9, 8'h06); rd(4'd8, rb); chk("R8 req set", rb, 8'h40);
    wr(4'd9, 8'h02); rd(4'd8, rb); chk("R8 req clr", rb, 8'h00);
  endtask

  task automatic t_steps;
    wr(4'd11, 8'h46);
    step(2); chk("R10 cnt dec", cur_cnt_o[2*AW +: AW], 16'h0002);
    chk("R10 addr inc", cur_addr_o[2*AW +: AW], 16'h1235);
    step(2); step(2); step(2);
    chk("R10 wrap", cur_cnt_o[2*AW +: AW], 16'hFFFF);
    chk("R10 base kept", base_cnt_o[2*AW +: AW], 16'h0003);
    wr(4'd12, 8'h00);
    wr(4'd2, 8'h10); wr(4'd2, 8'h00);
    wr(4'd3, 8'h01); wr(4'd3, 8'h00);
    wr(4'd11, 8'h31);
    step(1); chk("R10 addr dec", cur_addr_o[1*AW +: AW], 16'h000F);
    step(1); chk("R10 auto cnt", cur_cnt_o[1*AW +: AW], 16'h0001);
    chk("R10 auto addr", cur_addr_o[1*AW +: AW], 16'h0010);
    rd(4'd8, rb); chk("R9 tc flags", rb, 8'h06);
    rd(4'd8, rb); chk("R9 tc cleared", rb, 8'h00);
  endtask

  task automatic t_collide;
    // R9: status read and terminal count on the same edge
    @(negedge clk); io_addr = 4'd8; io_rd = 1; eng_step = 4'b0001;
    @(negedge clk); io_rd = 0; eng_step = '0; rb = io_rdata;
    chk("R9 same-cycle old", rb, 8'h00);
    rd(4'd8, rb); chk("R9 same-cycle kept", rb, 8'h01);
    eng_dreq = 4'b1000;
    rd(4'd8, rb); chk("R9 dreq", rb, 8'h80);
    eng_dreq = '0;
    // R12: host count write and step on the same edge
    wr(4'd12, 8'h00); wr(4'd7, 8'h05); wr(4'd7, 8'h00); wr(4'd12, 8'h00);
    @(negedge clk); io_addr = 4'd7; io_wdata = 8'h09; io_wr = 1; eng_step = 4'b1000;
    @(negedge clk); io_wr = 0; eng_step = '0;
    chk("R12 write wins", cur_cnt_o[3*AW +: AW], 16'h0009);
    chk("R12 addr still", cur_addr_o[3*AW +: AW], 16'h0000);
  endtask

  task automatic t_mclr;
    wr(4'd9, 8'h04); wr(4'd12, 8'h00); wr(4'd0, 8'h77);
    wr(4'd13, 8'h00);
    chk("R11 masks", ch_mask, 4'hF);
    chk("R11 modes", ch_mode, '0);
    chk("R11 cmd", cmd_out, 8'h00);
    chk("R11 addr kept", cur_addr_o[2*AW +: AW], 16'h1238);
    rd(4'd8, rb); chk("R11 status", rb, 8'h00);
    wr(4'd6, 8'h22); wr(4'd6, 8'h11);
    chk("R11 ptr low", cur_addr_o[3*AW +: AW], 16'h1122);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_load_read();
    t_ptr();
    t_masks();
    t_mode_cmd();
    t_steps();
    t_collide();
    t_mclr();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule